// File: doc/BRIEF.md
# Two-Level Interrupt Event Aggregator

This block collects single-cycle event pulses from several peripherals and turns them into one level-sensitive interrupt line per peripheral for the processor's interrupt controller. Each peripheral has a bank of event sources. Every source has a sticky flag bit and a mask bit. The flags of a bank, ANDed with its mask and ORed together, form a level request for that peripheral.

At the top level, each peripheral has a pending latch and an enable latch. Each latch has its own write-one-to-set and write-one-to-clear addresses. The interrupt line is pending AND enabled. No events are queued. When an enabled source fires again while its flag is still set, the later event is lost, and the loss is recorded in a per-peripheral missed-event bit.

Software reaches all state through a simple word-addressed register bus. It has a write strobe, an address, write data and registered read data. Bank `p` sits at word addresses `16 + 2*p` (flags) and `17 + 2*p` (mask).

Top module: `irq_hub`

## Requirements
- R1: The mask register of bank p at address 17+2p is read/write. Bit i set to 1 enables source i of that bank, and 0 disables it.
- R2: An event pulse on `evt_i[p*SRC_W+i]` sets flag i of bank p whatever the mask holds. Writing 1 to bit i at address 16+2p clears that flag. Writing 0 to a flag bit leaves it unchanged.
- R3: A bank's request is the OR over all bits of flag AND mask. Enabling a mask bit whose flag is already set raises the pending bit on the next clock edge.
- R4: If an event and a write-1 clear hit the same flag in the same cycle, the flag stays set.
- R5: An event on a source whose flag and mask are both set, and which is not being cleared in that cycle, sets missed-event bit p. The missed-event register is at address 4 (bit p = bank p) and is cleared by writing 1. A new miss wins over a clear in the same cycle.
- R6: Pending bit p is set by the bank request or by writing 1 at address 2. It is cleared by writing 1 at address 3. A set wins, so pending cannot be cleared while the request is active. Addresses 2 and 3 both read the pending vector.
- R7: Enable bit p is set by writing 1 at address 0 and cleared by writing 1 at address 1, with set winning. Addresses 0 and 1 both read the enable vector.
- R8: `irq_o[p]` equals pending[p] AND enable[p] as they stand after the same clock edge. An event that sets a flag at edge k therefore raises the line at edge k+1 if mask and enable are set.
- R9: `bus_rdata` is registered. After edge k it holds the register at the address presented at edge k, as it was before that edge's writes. Unmapped addresses read 0.
- R10: A synchronous active-high reset clears all flags, masks, pending, enable and missed-event bits, the interrupt lines and the read data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the current address |
| bus_addr | input | ADDR_W | Word address for read and write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| evt_i | input | NUM_PERIPH*SRC_W | Single-cycle event pulses, bank p in bits p*SRC_W upward |
| irq_o | output | NUM_PERIPH | Level interrupt per peripheral |

## Verification
The in-design properties assume that event inputs are one-cycle pulses sampled on the clock edge. They also assume that a write and its address are both stable for the edge that takes them, since flag and miss properties are stated one edge after the pulse. The stimulus drives every input half a period away from the rising edge. It draws sparse event pulses and mixed writes to mapped and unmapped addresses from a fixed-seed generator. Directed steps then place event and clear in the same cycle, repeat events on a pending flag, enable a mask after its flag, and clear the pending bit while the request is still active.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int unsigned A_EN_SET   = 0;
  localparam int unsigned A_EN_CLR   = 1;
  localparam int unsigned A_PEND_SET = 2;
  localparam int unsigned A_PEND_CLR = 3;
  localparam int unsigned A_MISS     = 4;
  localparam int unsigned A_BANK     = 16;

  function automatic int unsigned flag_addr(int p);
    return A_BANK + 2 * p;
  endfunction

  function automatic int unsigned mask_addr(int p);
    return A_BANK + 2 * p + 1;
  endfunction
endpackage

// File: rtl/irq_hub_srcbank.sv
module irq_hub_srcbank #(
  parameter int SRC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_W-1:0] evt_i,
  input  logic [SRC_W-1:0] flag_clr_i,
  input  logic             mask_we_i,
  input  logic [SRC_W-1:0] mask_d_i,
  input  logic             miss_clr_i,
  output logic [SRC_W-1:0] flag_o,
  output logic [SRC_W-1:0] mask_o,
  output logic             req_o,
  output logic             miss_o
);
  logic [SRC_W-1:0] flag_q, mask_q;
  logic             miss_q;
  logic             lost;

  // an enabled source fires again before software serviced it
  assign lost = |(evt_i & flag_q & mask_q & ~flag_clr_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      mask_q <= '0;
      miss_q <= 1'b0;
    end else begin
      flag_q <= (flag_q & ~flag_clr_i) | evt_i;
      if (mask_we_i) mask_q <= mask_d_i;
      miss_q <= lost | (miss_q & ~miss_clr_i);
    end
  end

  assign flag_o = flag_q;
  assign mask_o = mask_q;
  assign miss_o = miss_q;
  assign req_o  = |(flag_q & mask_q);

  AST_EVENT_KEEPS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (evt_i != '0) |=> ((flag_o & $past(evt_i)) == $past(evt_i))); // R4
  AST_IDLE_FLAG_STABLE: assert property (@(posedge clk) disable iff (rst)
    (evt_i == '0 && flag_clr_i == '0) |=> $stable(flag_o)); // R2
  AST_REPEAT_MARKS_MISS: assert property (@(posedge clk) disable iff (rst)
    ((evt_i & flag_o & mask_o & ~flag_clr_i) != '0) |=> miss_o); // R5
endmodule

// File: rtl/irq_hub_toplatch.sv
module irq_hub_toplatch #(
  parameter int NUM_PERIPH = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_PERIPH-1:0] req_i,
  input  logic [NUM_PERIPH-1:0] pset_i,
  input  logic [NUM_PERIPH-1:0] pclr_i,
  input  logic [NUM_PERIPH-1:0] eset_i,
  input  logic [NUM_PERIPH-1:0] eclr_i,
  output logic [NUM_PERIPH-1:0] pend_o,
  output logic [NUM_PERIPH-1:0] en_o,
  output logic [NUM_PERIPH-1:0] irq_o
);
  logic [NUM_PERIPH-1:0] pend_q, en_q, irq_q;
  logic [NUM_PERIPH-1:0] pend_n, en_n;

  always_comb begin
    pend_n = (pend_q & ~pclr_i) | pset_i | req_i;
    en_n   = (en_q & ~eclr_i) | eset_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      en_q   <= '0;
      irq_q  <= '0;
    end else begin
      pend_q <= pend_n;
      en_q   <= en_n;
      irq_q  <= pend_n & en_n;
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign irq_o  = irq_q;

  AST_REQ_HOLDS_PEND: assert property (@(posedge clk) disable iff (rst)
    (req_i != '0) |=> ((pend_o & $past(req_i)) == $past(req_i))); // R6
  AST_ENSET_WINS: assert property (@(posedge clk) disable iff (rst)
    (eset_i != '0) |=> ((en_o & $past(eset_i)) == $past(eset_i))); // R7
  AST_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (rst)
    ((pclr_i & ~req_i & ~pset_i) != '0) |=>
      ((irq_o & $past(pclr_i & ~req_i & ~pset_i)) == '0)); // R8
endmodule

// File: rtl/irq_hub_rdmux.sv
module irq_hub_rdmux
  import irq_hub_pkg::*;
#(
  parameter int NUM_PERIPH = 4,
  parameter int SRC_W      = 8,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [NUM_PERIPH*SRC_W-1:0] flags_i,
  input  logic [NUM_PERIPH*SRC_W-1:0] masks_i,
  input  logic [NUM_PERIPH-1:0]       pend_i,
  input  logic [NUM_PERIPH-1:0]       en_i,
  input  logic [NUM_PERIPH-1:0]       miss_i,
  output logic [DATA_W-1:0]           rdata_o
);
  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    if (addr_i == ADDR_W'(A_EN_SET) || addr_i == ADDR_W'(A_EN_CLR))
      sel = DATA_W'(en_i);
    if (addr_i == ADDR_W'(A_PEND_SET) || addr_i == ADDR_W'(A_PEND_CLR))
      sel = DATA_W'(pend_i);
    if (addr_i == ADDR_W'(A_MISS))
      sel = DATA_W'(miss_i);
    for (int p = 0; p < NUM_PERIPH; p++) begin
      if (addr_i == ADDR_W'(flag_addr(p))) sel = DATA_W'(flags_i[p*SRC_W +: SRC_W]);
      if (addr_i == ADDR_W'(mask_addr(p))) sel = DATA_W'(masks_i[p*SRC_W +: SRC_W]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= sel;
  end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int NUM_PERIPH = 4,
  parameter int SRC_W      = 8,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = (SRC_W > NUM_PERIPH) ? SRC_W : NUM_PERIPH
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        bus_we,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [DATA_W-1:0]           bus_wdata,
  output logic [DATA_W-1:0]           bus_rdata,
  input  logic [NUM_PERIPH*SRC_W-1:0] evt_i,
  output logic [NUM_PERIPH-1:0]       irq_o
);
  localparam int FLAT_W = NUM_PERIPH * SRC_W;

  logic [FLAT_W-1:0]     flags, masks;
  logic [NUM_PERIPH-1:0] req, miss, pend, en;
  logic [NUM_PERIPH-1:0] pset, pclr, eset, eclr;

  function automatic logic [NUM_PERIPH-1:0] w1_vec(int unsigned a, logic we,
      logic [ADDR_W-1:0] ad, logic [DATA_W-1:0] d);
    return (we && ad == ADDR_W'(a)) ? d[NUM_PERIPH-1:0] : '0;
  endfunction

  always_comb begin
    eset = w1_vec(A_EN_SET,   bus_we, bus_addr, bus_wdata);
    eclr = w1_vec(A_EN_CLR,   bus_we, bus_addr, bus_wdata);
    pset = w1_vec(A_PEND_SET, bus_we, bus_addr, bus_wdata);
    pclr = w1_vec(A_PEND_CLR, bus_we, bus_addr, bus_wdata);
  end

  for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_bank
    logic [SRC_W-1:0] clr;
    logic             mwe, mclr;
    assign clr  = (bus_we && bus_addr == ADDR_W'(flag_addr(p))) ? bus_wdata[SRC_W-1:0] : '0;
    assign mwe  = bus_we && bus_addr == ADDR_W'(mask_addr(p));
    assign mclr = bus_we && bus_addr == ADDR_W'(A_MISS) && bus_wdata[p];

    irq_hub_srcbank #(.SRC_W(SRC_W)) u_bank (
      .clk       (clk),
      .rst       (rst),
      .evt_i     (evt_i[p*SRC_W +: SRC_W]),
      .flag_clr_i(clr),
      .mask_we_i (mwe),
      .mask_d_i  (bus_wdata[SRC_W-1:0]),
      .miss_clr_i(mclr),
      .flag_o    (flags[p*SRC_W +: SRC_W]),
      .mask_o    (masks[p*SRC_W +: SRC_W]),
      .req_o     (req[p]),
      .miss_o    (miss[p])
    );
  end

  irq_hub_toplatch #(.NUM_PERIPH(NUM_PERIPH)) u_top (
    .clk   (clk),
    .rst   (rst),
    .req_i (req),
    .pset_i(pset),
    .pclr_i(pclr),
    .eset_i(eset),
    .eclr_i(eclr),
    .pend_o(pend),
    .en_o  (en),
    .irq_o (irq_o)
  );

  irq_hub_rdmux #(
    .NUM_PERIPH(NUM_PERIPH), .SRC_W(SRC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_rd (
    .clk    (clk),
    .rst    (rst),
    .addr_i (bus_addr),
    .flags_i(flags),
    .masks_i(masks),
    .pend_i (pend),
    .en_i   (en),
    .miss_i (miss),
    .rdata_o(bus_rdata)
  );

  AST_LATE_MASK_PROPAGATES: assert property (@(posedge clk) disable iff (rst)
    (req != '0) |=> ((pend & $past(req)) == $past(req))); // R3
  AST_READY_IRQ_RISES: assert property (@(posedge clk) disable iff (rst)
    ((req & en & ~eclr) != '0) |=> ((irq_o & $past(req & en & ~eclr)) == $past(req & en & ~eclr))); // R8
endmodule

// File: tb/irq_hub_bench.sv
module irq_hub_bench;
  import irq_hub_pkg::*;
  localparam int NP = 4;
  localparam int SW = 8;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          t_we = 1'b0;
  logic [AW-1:0] t_addr = '0;
  logic [DW-1:0] t_wdata = '0;
  logic [NP*SW-1:0] t_evt = '0;
  logic [DW-1:0] bus_rdata;
  logic [NP-1:0] irq_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_hub #(.NUM_PERIPH(NP), .SRC_W(SW), .ADDR_W(AW), .DATA_W(DW)) u_irq_hub (
    .clk(clk), .rst(rst), .bus_we(t_we), .bus_addr(t_addr), .bus_wdata(t_wdata),
    .bus_rdata(bus_rdata), .evt_i(t_evt), .irq_o(irq_o)
  );

  // reference state built from the requirements
  logic [SW-1:0] m_flag [NP];
  logic [SW-1:0] m_mask [NP];
  logic [NP-1:0] m_pend, m_en, m_miss, m_irq;
  logic [DW-1:0] m_rdata;
  logic [AW-1:0] m_raddr;

  function automatic logic [DW-1:0] rd_model(logic [AW-1:0] a);
    logic [DW-1:0] v = '0;
    if (a == AW'(A_EN_SET) || a == AW'(A_EN_CLR)) v = DW'(m_en);
    if (a == AW'(A_PEND_SET) || a == AW'(A_PEND_CLR)) v = DW'(m_pend);
    if (a == AW'(A_MISS)) v = DW'(m_miss);
    for (int p = 0; p < NP; p++) begin
      if (a == AW'(flag_addr(p))) v = m_flag[p];
      if (a == AW'(mask_addr(p))) v = m_mask[p];
    end
    return v;
  endfunction

  function automatic string tag_of(logic [AW-1:0] a);
    if (a <= AW'(A_EN_CLR)) return "R7";
    if (a <= AW'(A_PEND_CLR)) return "R6";
    if (a == AW'(A_MISS)) return "R5";
    if (a >= AW'(A_BANK) && a < AW'(A_BANK + 2*NP)) return a[0] ? "R1" : "R2";
    return "R9";
  endfunction

  function automatic logic [NP-1:0] w1(int unsigned a);
    return (t_we && t_addr == AW'(a)) ? t_wdata[NP-1:0] : '0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NP; p++) begin m_flag[p] = '0; m_mask[p] = '0; end
      m_pend = '0; m_en = '0; m_miss = '0; m_irq = '0; m_rdata = '0; m_raddr = '0;
    end else begin : upd
      logic [NP-1:0] req, lost, mc;
      logic [SW-1:0] clr, e;
      m_rdata = rd_model(t_addr);
      m_raddr = t_addr;
      req = '0; lost = '0;
      mc = w1(A_MISS);
      for (int p = 0; p < NP; p++) req[p] = |(m_flag[p] & m_mask[p]);
      for (int p = 0; p < NP; p++) begin
        clr = (t_we && t_addr == AW'(flag_addr(p))) ? t_wdata[SW-1:0] : '0;
        e = t_evt[p*SW +: SW];
        lost[p] = |(e & m_flag[p] & m_mask[p] & ~clr);
        m_flag[p] = (m_flag[p] & ~clr) | e;
        if (t_we && t_addr == AW'(mask_addr(p))) m_mask[p] = t_wdata[SW-1:0];
      end
      m_miss = lost | (m_miss & ~mc);
      m_pend = (m_pend & ~w1(A_PEND_CLR)) | w1(A_PEND_SET) | req;
      m_en = (m_en & ~w1(A_EN_CLR)) | w1(A_EN_SET);
      m_irq = m_pend & m_en;
    end
  end

  task automatic chk(string tag, logic [DW-1:0] got, logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic step(logic we, logic [AW-1:0] a, logic [DW-1:0] d, logic [NP*SW-1:0] e);
    @(negedge clk);
    if (!rst) begin
      chk("R8", DW'(irq_o), DW'(m_irq));
      chk(tag_of(m_raddr), bus_rdata, m_rdata);
    end
    t_we = we; t_addr = a; t_wdata = d; t_evt = e;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, '0, '0);
  endtask

  task automatic expect_rd(logic [AW-1:0] a, logic [DW-1:0] exp, string tag);
    step(1'b0, a, '0, '0);
    @(posedge clk); #1;
    chk(tag, bus_rdata, exp);
  endtask

  function automatic logic [NP*SW-1:0] ev(int p, int b);
    logic [NP*SW-1:0] v = '0;
    v[p*SW + b] = 1'b1;
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog got=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd7113);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    chk("R10", DW'(irq_o), '0);
    chk("R10", bus_rdata, '0);
    expect_rd(AW'(flag_addr(0)), 8'h00, "R10");

    step(1'b0, '0, '0, ev(1, 3));                 // masked event
    expect_rd(AW'(flag_addr(1)), 8'h08, "R2");
    chk("R3", DW'(irq_o), '0);
    step(1'b1, AW'(A_EN_SET), 8'h02, '0);
    step(1'b1, AW'(mask_addr(1)), 8'h08, '0);     // enable after flag
    idle(1);
    expect_rd(AW'(A_PEND_CLR), 8'h02, "R3");
    chk("R8", DW'(irq_o), 8'h02);
    step(1'b1, AW'(A_PEND_CLR), 8'h02, '0);        // request still active
    idle(1);
    expect_rd(AW'(A_PEND_SET), 8'h02, "R6");
    step(1'b1, AW'(flag_addr(1)), 8'h08, ev(1, 3)); // clear and event together
    expect_rd(AW'(flag_addr(1)), 8'h08, "R4");
    expect_rd(AW'(A_MISS), 8'h00, "R5");
    step(1'b0, '0, '0, ev(1, 3));                   // repeat on pending flag
    expect_rd(AW'(A_MISS), 8'h02, "R5");
    step(1'b1, AW'(A_MISS), 8'h00, '0);
    expect_rd(AW'(A_MISS), 8'h02, "R5");
    step(1'b1, AW'(A_MISS), 8'h02, '0);
    expect_rd(AW'(A_MISS), 8'h00, "R5");
    step(1'b1, AW'(flag_addr(1)), 8'h00, '0);      // zero write
    expect_rd(AW'(flag_addr(1)), 8'h08, "R2");
    expect_rd(AW'(mask_addr(1)), 8'h08, "R1");
    step(1'b1, AW'(flag_addr(1)), 8'h08, '0);
    step(1'b1, AW'(A_PEND_CLR), 8'h02, '0);
    idle(1);
    expect_rd(AW'(A_PEND_SET), 8'h00, "R6");
    chk("R8", DW'(irq_o), 8'h00);
    step(1'b1, AW'(A_PEND_SET), 8'h02, '0);
    idle(1);
    chk("R8", DW'(irq_o), 8'h02);
    step(1'b1, AW'(A_EN_CLR), 8'h02, '0);
    idle(1);
    chk("R7", DW'(irq_o), 8'h00);
    expect_rd(AW'(A_EN_SET), 8'h00, "R7");
    expect_rd(AW'(8'h30), 8'h00, "R9");

    for (int c = 0; c < 4000; c++) begin
      logic [NP*SW-1:0] e = '0;
      int unsigned k;
      logic [AW-1:0] a;
      for (int b = 0; b < NP*SW; b++) e[b] = ($urandom_range(0, 15) == 0);
      k = $urandom_range(0, 14);
      a = (k < 5) ? AW'(k) : (k < 13) ? AW'(A_BANK + k - 5) : AW'(8'h30);
      step($urandom_range(0, 1) == 1, a, DW'($urandom), e);
    end

    step(1'b0, '0, '0, '0);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    chk("R10", DW'(irq_o), '0);
    expect_rd(AW'(A_PEND_SET), 8'h00, "R10");
    expect_rd(AW'(mask_addr(2)), 8'h00, "R10");
    idle(2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule